// File: doc/BRIEF.md
# Shifted-Operand Inverting Move Unit

This block is the execute slice of a move-not operation. It takes one source word, passes it through a barrel shifter selected by a 2-bit shift kind and a 5-bit immediate amount, and inverts every bit of the shifted word. The inverted word is captured in a result register. On request, the negative, zero and carry flags are captured as well. The carry comes from the shifter, so a shift result and a flag result can both depend on the same input bit.

A zero amount field has a special meaning for three of the four shift kinds. For logical-left it leaves the word unshifted. For logical-right and arithmetic-right it means a shift by the full word width. For rotate it means a one-bit rotate through the incoming carry. A separate narrow-form input forces an unshifted operand. In that form, the flag request is also suppressed while the instruction sits inside a conditional block. When the condition input is low, the slice writes nothing.

Top module: `nsh_not_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `n_o`, `z_o`, `c_o`, `v_o`, `valid_o` and `flags_wr_o` all become 0.
- R2: When `cond_ok_i` is high at an edge, `result_o` after that edge is the bitwise inverse of the shifted source, and `valid_o` is high for exactly that one cycle.
- R3: The shift kind is coded as `shtype_i` 00 = logical left, 01 = logical right, 10 = arithmetic right, 11 = rotate right. For amounts 1 to 31, the shifter carry is the last bit moved out (for rotate, bit 31 of the rotated word).
- R4: Logical left with amount 0 passes the source through unchanged, and the shifter carry equals `carry_i`.
- R5: Logical right with amount field 0 shifts by 32: the shifted word is 0 and the carry is source bit 31.
- R6: Arithmetic right with amount field 0 shifts by 32: every shifted bit and the carry equal source bit 31.
- R7: Rotate with amount field 0 is a rotate by one through carry: shifted bit 31 is `carry_i`, bits 30..0 are source bits 31..1, and the carry is source bit 0.
- R8: On a flag write, `n_o` is result bit 31, `z_o` is 1 exactly when the result is all zeros, and `c_o` is the shifter carry.
- R9: On a flag write, `v_o` takes the value of `v_i`, which is never altered by the operation, and `flags_wr_o` is high for that one cycle.
- R10: When the effective set-flags request is low, `n_o`, `z_o`, `c_o` and `v_o` keep their values and `flags_wr_o` stays low.
- R11: When `cond_ok_i` is low, `valid_o` and `flags_wr_o` are low, and the result and the flags keep their values.
- R12: When `narrow_i` is high, the shift is logical left by 0 whatever `shtype_i` and `shamt_i` hold, and flags are written only if `setflags_i` is high and `in_it_i` is low. When `narrow_i` is low, `in_it_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_ok_i | input | 1 | Condition passed; enables the writes |
| narrow_i | input | 1 | Short form: unshifted operand, gated flag request |
| in_it_i | input | 1 | Instruction lies inside a conditional block |
| setflags_i | input | 1 | Flag update requested |
| shtype_i | input | 2 | Shift kind |
| shamt_i | input | 5 | Immediate shift amount field |
| src_i | input | 32 | Source operand |
| carry_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| valid_o | output | 1 | One-cycle pulse with each new result |
| flags_wr_o | output | 1 | One-cycle pulse when the flags were written |
| result_o | output | 32 | Registered inverted shifted word |
| n_o | output | 1 | Registered negative flag |
| z_o | output | 1 | Registered zero flag |
| c_o | output | 1 | Registered carry flag |
| v_o | output | 1 | Registered overflow flag |

## Verification
The two functions that meet in one cycle are the shifter's carry-out and the flag computation on the inverted word. In several cases, such as logical right by 32 or arithmetic right by 32, one source bit sets both the shifted data and the carry. The bench provokes this with boundary words that make the result all ones or all zeros while the carry differs from `carry_i`. It then compares the result and all flags together against a scoreboard entry produced by a separate one-bit-at-a-time reference shifter. The same cycle also mixes a failing condition or a narrow-form flag gate with a changed `v_i`, and the bench checks that the held flag state survives.

// File: rtl/nsh_pkg.sv
package nsh_pkg;

    // Encoded shift kind on the input port
    typedef enum logic [1:0] {
        TY_LSL = 2'b00,
        TY_LSR = 2'b01,
        TY_ASR = 2'b10,
        TY_ROR = 2'b11
    } shtype_e;

    // Internal shift operation after immediate decoding
    typedef enum logic [2:0] {
        OP_LSL = 3'd0,
        OP_LSR = 3'd1,
        OP_ASR = 3'd2,
        OP_ROR = 3'd3,
        OP_RRX = 3'd4
    } shop_e;

endpackage

// File: rtl/nsh_amt_decode.sv
module nsh_amt_decode
    import nsh_pkg::*;
#(
    parameter int W  = 32,
    localparam int SW = $clog2(W),
    localparam int AW = SW + 1
) (
    input  logic          narrow_i,
    input  logic [1:0]    shtype_i,
    input  logic [SW-1:0] shamt_i,
    output shop_e         op_o,
    output logic [AW-1:0] amt_o
);

    localparam logic [AW-1:0] FULL = AW'(W);

    logic field_zero;

    always_comb begin
        field_zero = (shamt_i == '0);
        op_o       = OP_LSL;
        amt_o      = {1'b0, shamt_i};
        if (narrow_i) begin
            // short form: no shift at all
            op_o  = OP_LSL;
            amt_o = '0;
        end else begin
            unique case (shtype_e'(shtype_i))
                TY_LSL: op_o = OP_LSL;
                TY_LSR: begin
                    op_o = OP_LSR;
                    if (field_zero) amt_o = FULL;
                end
                TY_ASR: begin
                    op_o = OP_ASR;
                    if (field_zero) amt_o = FULL;
                end
                TY_ROR: begin
                    op_o = field_zero ? OP_RRX : OP_ROR;
                    if (field_zero) amt_o = AW'(1);
                end
                default: op_o = OP_LSL;
            endcase
        end
    end

endmodule

// File: rtl/nsh_shifter.sv
module nsh_shifter
    import nsh_pkg::*;
#(
    parameter int W  = 32,
    localparam int AW = $clog2(W) + 1
) (
    input  shop_e         op_i,
    input  logic [AW-1:0] amt_i,
    input  logic [W-1:0]  x_i,
    input  logic          cin_i,
    output logic [W-1:0]  y_o,
    output logic          cout_o
);

    // Guard-bit extended forms: the extra bit catches the last bit moved out
    logic [W:0]    lwide;
    logic [W:0]    rwide;
    logic [W:0]    awide;
    logic [W-1:0]  rot;
    logic [AW-1:0] back;

    always_comb begin
        lwide = {1'b0, x_i} << amt_i;
        rwide = {x_i, 1'b0} >> amt_i;
        awide = (W+1)'($signed({x_i, 1'b0}) >>> amt_i);
        back  = AW'(W) - amt_i;
        rot   = (x_i >> amt_i) | (x_i << back);
    end

    always_comb begin
        y_o    = x_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_LSL: begin
                y_o    = lwide[W-1:0];
                cout_o = (amt_i == '0) ? cin_i : lwide[W];
            end
            OP_LSR: begin
                y_o    = rwide[W:1];
                cout_o = rwide[0];
            end
            OP_ASR: begin
                y_o    = awide[W:1];
                cout_o = awide[0];
            end
            OP_ROR: begin
                y_o    = rot;
                cout_o = rot[W-1];
            end
            OP_RRX: begin
                y_o    = {cin_i, x_i[W-1:1]};
                cout_o = x_i[0];
            end
            default: begin
                y_o    = x_i;
                cout_o = cin_i;
            end
        endcase
    end

endmodule

// File: rtl/nsh_flags.sv
module nsh_flags #(
    parameter int W     = 32,
    parameter int CHUNK = 8,
    localparam int NCH  = (W + CHUNK - 1) / CHUNK
) (
    input  logic [W-1:0] res_i,
    output logic         n_o,
    output logic         z_o
);

    logic [NCH-1:0] chunk_nz;

    // Two-level zero detect: OR within chunks, then across chunks
    for (genvar g = 0; g < NCH; g++) begin : g_chunk
        localparam int LO = g * CHUNK;
        localparam int HI = ((g + 1) * CHUNK > W) ? W - 1 : (g + 1) * CHUNK - 1;
        assign chunk_nz[g] = |res_i[HI:LO];
    end

    assign n_o = res_i[W-1];
    assign z_o = ~|chunk_nz;

endmodule

// File: rtl/nsh_not_unit.sv
module nsh_not_unit
    import nsh_pkg::*;
#(
    parameter int W  = 32,
    localparam int SW = $clog2(W),
    localparam int AW = SW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cond_ok_i,
    input  logic          narrow_i,
    input  logic          in_it_i,
    input  logic          setflags_i,
    input  logic [1:0]    shtype_i,
    input  logic [SW-1:0] shamt_i,
    input  logic [W-1:0]  src_i,
    input  logic          carry_i,
    input  logic          v_i,
    output logic          valid_o,
    output logic          flags_wr_o,
    output logic [W-1:0]  result_o,
    output logic          n_o,
    output logic          z_o,
    output logic          c_o,
    output logic          v_o
);

    typedef struct packed {
        logic         vld;
        logic         fwr;
        logic         n;
        logic         z;
        logic         c;
        logic         v;
        logic [W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    shop_e         op;
    logic [AW-1:0] amt;
    logic [W-1:0]  shifted;
    logic          sh_carry;
    logic [W-1:0]  inv;
    logic          nf;
    logic          zf;
    logic          sf_eff;

    nsh_amt_decode #(.W(W)) i_dec (
        .narrow_i (narrow_i),
        .shtype_i (shtype_i),
        .shamt_i  (shamt_i),
        .op_o     (op),
        .amt_o    (amt)
    );

    nsh_shifter #(.W(W)) i_sh (
        .op_i   (op),
        .amt_i  (amt),
        .x_i    (src_i),
        .cin_i  (carry_i),
        .y_o    (shifted),
        .cout_o (sh_carry)
    );

    assign inv = ~shifted;

    nsh_flags #(.W(W)) i_fl (
        .res_i (inv),
        .n_o   (nf),
        .z_o   (zf)
    );

    always_comb begin
        sf_eff   = setflags_i & ~(narrow_i & in_it_i);
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.fwr = 1'b0;
        if (cond_ok_i) begin
            st_d.vld = 1'b1;
            st_d.res = inv;
            if (sf_eff) begin
                st_d.fwr = 1'b1;
                st_d.n   = nf;
                st_d.z   = zf;
                st_d.c   = sh_carry;
                st_d.v   = v_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign valid_o    = st_q.vld;
    assign flags_wr_o = st_q.fwr;
    assign result_o   = st_q.res;
    assign n_o        = st_q.n;
    assign z_o        = st_q.z;
    assign c_o        = st_q.c;
    assign v_o        = st_q.v;

    AST_VALID_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(cond_ok_i)); // R11
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(result_o)); // R11
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flags_wr_o |-> $stable({n_o, z_o, c_o, v_o})); // R10
    AST_FWR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        flags_wr_o |-> valid_o); // R10
    AST_V_COPY: assert property (@(posedge clk) disable iff (rst)
        flags_wr_o |-> v_o == $past(v_i)); // R9
    AST_N_IS_MSB: assert property (@(posedge clk) disable iff (rst)
        flags_wr_o |-> n_o == result_o[W-1]); // R8
    AST_Z_MATCH: assert property (@(posedge clk) disable iff (rst)
        flags_wr_o |-> z_o == (result_o == '0)); // R8
    AST_NARROW_GATE: assert property (@(posedge clk) disable iff (rst)
        flags_wr_o |-> !$past(narrow_i && in_it_i)); // R12
    AST_NARROW_PASS: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(narrow_i)) |-> result_o == ~$past(src_i)); // R12

endmodule

// File: tb/test_nsh_not_unit.sv
module test_nsh_not_unit;

    localparam int W = 32;

    typedef struct {
        logic          vld;
        logic          fwr;
        logic [W-1:0]  res;
        logic          n, z, c, v;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cond_ok_i = 1'b0;
    logic          narrow_i = 1'b0;
    logic          in_it_i = 1'b0;
    logic          setflags_i = 1'b0;
    logic [1:0]    shtype_i = 2'b00;
    logic [4:0]    shamt_i = 5'd0;
    logic [W-1:0]  src_i = '0;
    logic          carry_i = 1'b0;
    logic          v_i = 1'b0;
    logic          valid_o, flags_wr_o, n_o, z_o, c_o, v_o;
    logic [W-1:0]  result_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    exp_t q[$];

    // bench-side model state
    logic [W-1:0] m_res = '0;
    logic m_n = 1'b0, m_z = 1'b0, m_c = 1'b0, m_v = 1'b0;

    always #5 clk = ~clk;

    nsh_not_unit i_nsh_not_unit (
        .clk(clk), .rst(rst), .cond_ok_i(cond_ok_i), .narrow_i(narrow_i),
        .in_it_i(in_it_i), .setflags_i(setflags_i), .shtype_i(shtype_i),
        .shamt_i(shamt_i), .src_i(src_i), .carry_i(carry_i), .v_i(v_i),
        .valid_o(valid_o), .flags_wr_o(flags_wr_o), .result_o(result_o),
        .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o)
    );

    // Reference shifter: moves one bit per step
    task automatic ref_shift(input logic [1:0] ty, input logic [4:0] a,
                             input logic [W-1:0] x, input logic ci,
                             output logic [W-1:0] y, output logic co);
        int steps;
        y = x;
        co = ci;
        steps = int'(a);
        case (ty)
            2'b00: for (int i = 0; i < steps; i++) begin co = y[W-1]; y = {y[W-2:0], 1'b0}; end
            2'b01: begin
                if (steps == 0) steps = W;
                for (int i = 0; i < steps; i++) begin co = y[0]; y = {1'b0, y[W-1:1]}; end
            end
            2'b10: begin
                if (steps == 0) steps = W;
                for (int i = 0; i < steps; i++) begin co = y[0]; y = {y[W-1], y[W-1:1]}; end
            end
            default: begin
                if (steps == 0) begin co = y[0]; y = {ci, y[W-1:1]}; end
                else for (int i = 0; i < steps; i++) begin co = y[0]; y = {y[0], y[W-1:1]}; end
            end
        endcase
    endtask

    task automatic apply(input logic cnd, input logic nar, input logic it,
                         input logic sf, input logic [1:0] ty, input logic [4:0] a,
                         input logic [W-1:0] x, input logic ci, input logic vi,
                         input string req);
        exp_t e;
        logic [W-1:0] y;
        logic co, sfe;
        @(negedge clk);
        cond_ok_i = cnd; narrow_i = nar; in_it_i = it; setflags_i = sf;
        shtype_i = ty; shamt_i = a; src_i = x; carry_i = ci; v_i = vi;
        if (nar) ref_shift(2'b00, 5'd0, x, ci, y, co);
        else     ref_shift(ty, a, x, ci, y, co);
        sfe = sf && !(nar && it);
        e.vld = cnd;
        e.fwr = cnd && sfe;
        if (cnd) begin
            m_res = ~y;
            if (sfe) begin
                m_n = m_res[W-1]; m_z = (m_res == '0); m_c = co; m_v = vi;
            end
        end
        e.res = m_res; e.n = m_n; e.z = m_z; e.c = m_c; e.v = m_v; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        apply(1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 5'd3, 32'h1234_5678, 1'b1, 1'b1, req);
    endtask

    // Monitor: compares each registered result against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (valid_o !== e.vld || flags_wr_o !== e.fwr || result_o !== e.res ||
                    n_o !== e.n || z_o !== e.z || c_o !== e.c || v_o !== e.v) begin
                    errors++;
                    $display("FAIL %s: got vld=%b fwr=%b res=%h nzcv=%b%b%b%b, expected vld=%b fwr=%b res=%h nzcv=%b%b%b%b",
                             e.req, valid_o, flags_wr_o, result_o, n_o, z_o, c_o, v_o,
                             e.vld, e.fwr, e.res, e.n, e.z, e.c, e.v);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;  // R1 reset state
        if (valid_o !== 1'b0 || flags_wr_o !== 1'b0 || result_o !== '0 ||
            {n_o, z_o, c_o, v_o} !== 4'b0000) begin
            errors++;
            $display("FAIL R1: got vld=%b fwr=%b res=%h nzcv=%b%b%b%b, expected all zero",
                     valid_o, flags_wr_o, result_o, n_o, z_o, c_o, v_o);
        end
        rst = 1'b0;
        mon_on = 1'b1;

        apply(1, 0, 0, 1, 2'b00, 5'd0, 32'h0F0F_00FF, 1'b1, 1'b0, "R4 LSL0 carry in 1");
        apply(1, 0, 0, 1, 2'b00, 5'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4 LSL0 carry in 0 zero");
        apply(1, 0, 0, 1, 2'b00, 5'd4, 32'hF000_0001, 1'b0, 1'b1, "R3 LSL4 carry");
        apply(1, 0, 0, 1, 2'b01, 5'd1, 32'h0000_0003, 1'b0, 1'b0, "R3 LSR1");
        apply(1, 0, 0, 1, 2'b01, 5'd0, 32'h8000_0001, 1'b0, 1'b0, "R5 LSR32");
        apply(1, 0, 0, 1, 2'b10, 5'd0, 32'h8000_0000, 1'b0, 1'b1, "R6 ASR32 neg");
        apply(1, 0, 0, 1, 2'b10, 5'd0, 32'h7FFF_FFFF, 1'b1, 1'b0, "R6 ASR32 pos");
        apply(1, 0, 0, 1, 2'b10, 5'd31, 32'h8000_0000, 1'b0, 1'b0, "R3 ASR31");
        apply(1, 0, 0, 1, 2'b11, 5'd0, 32'h0000_0003, 1'b1, 1'b0, "R7 RRX cin 1");
        apply(1, 0, 0, 1, 2'b11, 5'd0, 32'h8000_0002, 1'b0, 1'b1, "R7 RRX cin 0");
        apply(1, 0, 0, 1, 2'b11, 5'd8, 32'h0000_0080, 1'b0, 1'b0, "R3 ROR8 carry msb");
        apply(1, 0, 0, 1, 2'b00, 5'd31, 32'h0000_0003, 1'b0, 1'b0, "R8 N and Z");
        apply(1, 0, 0, 0, 2'b01, 5'd0, 32'h0000_0000, 1'b1, 1'b0, "R10 no setflags");
        apply(0, 0, 0, 1, 2'b10, 5'd0, 32'hFFFF_FFFF, 1'b0, 1'b1, "R11 cond fail");
        apply(1, 0, 0, 1, 2'b01, 5'd2, 32'h0000_0002, 1'b1, 1'b1, "R9 V copied");
        apply(1, 1, 1, 1, 2'b11, 5'd5, 32'h1357_9BDF, 1'b0, 1'b0, "R12 narrow in block");
        apply(1, 1, 0, 1, 2'b11, 5'd5, 32'h8000_0000, 1'b1, 1'b0, "R12 narrow outside");
        apply(1, 0, 1, 1, 2'b01, 5'd0, 32'h8000_0000, 1'b0, 1'b1, "R12 in_it ignored wide");
        apply(1, 0, 0, 1, 2'b00, 5'd0, 32'h0000_0000, 1'b0, 1'b0, "R2 inversion");
        idle("R11 idle hold");
        idle("R11 idle hold");

        for (int k = 0; k < 400; k++) begin
            apply(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) == 0),
                  1'($urandom), 1'($urandom), 2'($urandom), 5'($urandom),
                  $urandom, 1'($urandom), 1'($urandom), "R2,R3 mixed");
        end
        idle("R11 drain");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule